// File: doc/BRIEF.md
# Interrupt Pending-Bit Relocator

This block moves the pending state of a single message-signalled interrupt from one CPU's pending table to another CPU. Each CPU keeps its pending table in byte-addressed memory as a flat bit array: interrupt `n` lives in byte `n/8` at bit `n%8`. When a move request arrives, the block checks the request against both CPUs' configurations. If the move is legal, it reads the byte from the source table. If the bit is set, it clears the bit and writes the byte back. It then tells the destination CPU's pending logic to mark the interrupt pending.

Per-CPU configuration comes in on flat buses: an enable bit, an ID-width field and a pending-table base address, plus the ID that each CPU currently rates as its best pending interrupt. When the moved interrupt was the source's best, the block asks for a priority recomputation on that source. It does not perform the recomputation itself. Every accepted request ends with a one-cycle `done` pulse, including requests that end without touching memory.

Top module: `lpi_mv_unit`

## Requirements
- R1: After reset, `done`, `busy`, `mem_rd_valid`, `mem_wr_valid`, `dst_set_valid` and `hpp_upd_valid` are all low.
- R2: If the enable bit of the source or of the destination CPU is 0, the request ends with `done` and no memory read, no memory write and no notification.
- R3: The effective ID width is the smallest of the source field, the destination field and the parameter `MAX_IDBITS`. An ID whose byte index (ID/8) is at or above 2^(width+1) ends with `done` and no memory access and no notification.
- R4: The read address equals the source base with bits below `PA_LO` forced to zero, plus ID/8.
- R5: If bit ID%8 of the returned byte is 0, the request ends with `done` and no write and no notification.
- R6: If bit ID%8 is 1, the same byte is written to the read address with only that bit cleared.
- R7: After the write, `hpp_upd_valid` pulses with `hpp_upd_cpu` equal to the source index only when the ID equals the source's current best pending ID.
- R8: After the write, `dst_set_valid` pulses once, carrying the destination index and the ID. `done` follows in the next cycle.
- R9: `done` is a one-cycle pulse and ends each accepted request exactly once. A `req_valid` that arrives while `busy` is high is ignored.
- R10: `mem_rd_valid` and `mem_wr_valid` stay high, with stable address and data, until their ready is seen. At most one of read, write, destination set and done is active in any cycle.
- R11: A source or destination index at or above `NUM_CPU` ends the request with `done` and no memory access and no notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a move (taken when idle) |
| req_id | input | ID_W | Interrupt ID to move |
| req_src | input | CPU_W | Source CPU index |
| req_dst | input | CPU_W | Destination CPU index |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| cpu_en | input | NUM_CPU | Per-CPU interrupt enable |
| cpu_idbits | input | NUM_CPU*IDB_W | Per-CPU ID-width fields |
| cpu_pend_base | input | NUM_CPU*ADDR_W | Per-CPU pending table base |
| cpu_best_id | input | NUM_CPU*ID_W | Per-CPU current best pending ID |
| mem_rd_valid | output | 1 | Byte read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 8 | Read data byte |
| mem_wr_valid | output | 1 | Byte write request |
| mem_wr_ready | input | 1 | Write accepted |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 8 | Write data byte |
| hpp_upd_valid | output | 1 | Recompute-best request pulse |
| hpp_upd_cpu | output | CPU_W | CPU to recompute |
| dst_set_valid | output | 1 | Set-pending pulse to destination |
| dst_set_cpu | output | CPU_W | Destination CPU |
| dst_set_id | output | ID_W | ID to mark pending |

## Verification
The bench builds the block with `NUM_CPU` = 3. Index 3 is therefore encodable but invalid, which makes the skip for out-of-range indices reachable. `MAX_IDBITS` = 10 sits below both ID-width fields when they are set to their maximum, so the global clamp decides the table bound and IDs 0x3FFF and 0x4000 fall on either side of it. `PA_LO` = 12 together with base addresses that carry low garbage bits shows the masking in the read address. A responder with adjustable stall cycles holds the read and write ready low for several cycles.

// File: rtl/lpi_mv_pkg.sv
package lpi_mv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CHECK,
      ST_RD,
      ST_RSP,
      ST_WR,
      ST_NOTIFY,
      ST_FIN
   } mv_state_e;
endpackage

// File: rtl/lpi_mv_bound.sv
module lpi_mv_bound #(
   parameter int ID_W       = 16,
   parameter int IDB_W      = 5,
   parameter int MAX_IDBITS = 15
) (
   input  logic [ID_W-1:0]  id,
   input  logic [IDB_W-1:0] src_bits,
   input  logic [IDB_W-1:0] dst_bits,
   output logic             in_range
);
   logic [IDB_W-1:0] pair_min;
   logic [IDB_W-1:0] eff_bits;
   logic [IDB_W:0]   shamt;
   logic [ID_W-1:0]  byte_idx;

   assign pair_min = (src_bits < dst_bits) ? src_bits : dst_bits;

   generate
      if (MAX_IDBITS >= (2**IDB_W) - 1) begin : g_noclamp
         assign eff_bits = pair_min;
      end else begin : g_clamp
         localparam logic [IDB_W-1:0] MAX_L = IDB_W'(MAX_IDBITS);
         assign eff_bits = (pair_min > MAX_L) ? MAX_L : pair_min;
      end
   endgenerate

   assign shamt    = {1'b0, eff_bits} + 1'b1;
   assign byte_idx = id >> 3;
   assign in_range = ((byte_idx >> shamt) == '0);
endmodule

// File: rtl/lpi_mv_addr.sv
module lpi_mv_addr #(
   parameter int ADDR_W = 48,
   parameter int ID_W   = 16,
   parameter int PA_LO  = 16
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [ID_W-1:0]   id,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [2:0]        bit_sel
);
   logic [ADDR_W-1:0] masked;
   logic [ADDR_W-1:0] offset;

   generate
      if (PA_LO == 0) begin : g_nomask
         assign masked = base;
      end else begin : g_mask
         localparam logic [ADDR_W-1:0] PA_MASK = {{(ADDR_W-PA_LO){1'b1}}, {PA_LO{1'b0}}};
         assign masked = base & PA_MASK;
      end
   endgenerate

   assign offset    = {{(ADDR_W-(ID_W-3)){1'b0}}, id[ID_W-1:3]};
   assign byte_addr = masked + offset;
   assign bit_sel   = id[2:0];
endmodule

// File: rtl/lpi_mv_unit.sv
module lpi_mv_unit
   import lpi_mv_pkg::*;
#(
   parameter int NUM_CPU    = 4,
   parameter int ID_W       = 16,
   parameter int IDB_W      = 5,
   parameter int MAX_IDBITS = 15,
   parameter int ADDR_W     = 48,
   parameter int PA_LO      = 16,
   localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [ID_W-1:0]             req_id,
   input  logic [CPU_W-1:0]            req_src,
   input  logic [CPU_W-1:0]            req_dst,
   output logic                        busy,
   output logic                        done,
   input  logic [NUM_CPU-1:0]          cpu_en,
   input  logic [NUM_CPU*IDB_W-1:0]    cpu_idbits,
   input  logic [NUM_CPU*ADDR_W-1:0]   cpu_pend_base,
   input  logic [NUM_CPU*ID_W-1:0]     cpu_best_id,
   output logic                        mem_rd_valid,
   input  logic                        mem_rd_ready,
   output logic [ADDR_W-1:0]           mem_rd_addr,
   input  logic                        mem_rsp_valid,
   input  logic [7:0]                  mem_rsp_data,
   output logic                        mem_wr_valid,
   input  logic                        mem_wr_ready,
   output logic [ADDR_W-1:0]           mem_wr_addr,
   output logic [7:0]                  mem_wr_data,
   output logic                        hpp_upd_valid,
   output logic [CPU_W-1:0]            hpp_upd_cpu,
   output logic                        dst_set_valid,
   output logic [CPU_W-1:0]            dst_set_cpu,
   output logic [ID_W-1:0]             dst_set_id
);
   generate
      if (NUM_CPU < 1) begin : g_bad_cpu
         $error("NUM_CPU must be at least 1");
      end
      if (ID_W < 4) begin : g_bad_id
         $error("ID_W must be at least 4");
      end
      if (ADDR_W <= ID_W - 3) begin : g_bad_addr
         $error("ADDR_W must exceed ID_W-3");
      end
      if (PA_LO >= ADDR_W || PA_LO < 0) begin : g_bad_pa
         $error("PA_LO out of range");
      end
   endgenerate

   mv_state_e           state;
   logic [ID_W-1:0]     cur_id;
   logic [CPU_W-1:0]    cur_src;
   logic [CPU_W-1:0]    cur_dst;
   logic [ADDR_W-1:0]   addr_q;
   logic [2:0]          bit_q;
   logic [7:0]          byte_q;

   logic [IDB_W-1:0]    idb_a  [NUM_CPU];
   logic [ADDR_W-1:0]   base_a [NUM_CPU];
   logic [ID_W-1:0]     best_a [NUM_CPU];

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CPU; gi++) begin : g_unpack
         assign idb_a[gi]  = cpu_idbits[gi*IDB_W +: IDB_W];
         assign base_a[gi] = cpu_pend_base[gi*ADDR_W +: ADDR_W];
         assign best_a[gi] = cpu_best_id[gi*ID_W +: ID_W];
      end
   endgenerate

   logic src_ok, dst_ok;
   generate
      if ((2**CPU_W) > NUM_CPU) begin : g_idx_chk
         assign src_ok = (32'(cur_src) < NUM_CPU);
         assign dst_ok = (32'(cur_dst) < NUM_CPU);
      end else begin : g_idx_full
         assign src_ok = 1'b1;
         assign dst_ok = 1'b1;
      end
   endgenerate

   logic [CPU_W-1:0] src_sel, dst_sel;
   assign src_sel = src_ok ? cur_src : '0;
   assign dst_sel = dst_ok ? cur_dst : '0;

   logic              in_range;
   logic [ADDR_W-1:0] calc_addr;
   logic [2:0]        calc_bit;
   logic              skip;

   lpi_mv_bound #(.ID_W(ID_W), .IDB_W(IDB_W), .MAX_IDBITS(MAX_IDBITS)) i_bound (
      .id(cur_id), .src_bits(idb_a[src_sel]), .dst_bits(idb_a[dst_sel]),
      .in_range(in_range)
   );

   lpi_mv_addr #(.ADDR_W(ADDR_W), .ID_W(ID_W), .PA_LO(PA_LO)) i_addr (
      .base(base_a[src_sel]), .id(cur_id),
      .byte_addr(calc_addr), .bit_sel(calc_bit)
   );

   assign skip = !src_ok || !dst_ok || !cpu_en[src_sel] || !cpu_en[dst_sel] || !in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur_id  <= '0;
         cur_src <= '0;
         cur_dst <= '0;
         addr_q  <= '0;
         bit_q   <= '0;
         byte_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               cur_id  <= req_id;
               cur_src <= req_src;
               cur_dst <= req_dst;
               state   <= ST_CHECK;
            end
            ST_CHECK: begin
               addr_q <= calc_addr;
               bit_q  <= calc_bit;
               state  <= skip ? ST_FIN : ST_RD;
            end
            ST_RD: if (mem_rd_ready) state <= ST_RSP;
            ST_RSP: if (mem_rsp_valid) begin
               if (mem_rsp_data[bit_q]) begin
                  byte_q <= mem_rsp_data & ~(8'd1 << bit_q);
                  state  <= ST_WR;
               end else begin
                  state  <= ST_FIN;
               end
            end
            ST_WR: if (mem_wr_ready) state <= ST_NOTIFY;
            ST_NOTIFY: state <= ST_FIN;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy          = (state != ST_IDLE);
   assign done          = (state == ST_FIN);
   assign mem_rd_valid  = (state == ST_RD);
   assign mem_rd_addr   = addr_q;
   assign mem_wr_valid  = (state == ST_WR);
   assign mem_wr_addr   = addr_q;
   assign mem_wr_data   = byte_q;
   assign dst_set_valid = (state == ST_NOTIFY);
   assign dst_set_cpu   = cur_dst;
   assign dst_set_id    = cur_id;
   assign hpp_upd_valid = (state == ST_NOTIFY) && (best_a[src_sel] == cur_id);
   assign hpp_upd_cpu   = cur_src;
endmodule

module lpi_mv_chk #(
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              mem_rd_valid,
   input logic              mem_rd_ready,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_wr_valid,
   input logic              mem_wr_ready,
   input logic [ADDR_W-1:0] mem_wr_addr,
   input logic [7:0]        mem_wr_data,
   input logic              hpp_upd_valid,
   input logic              dst_set_valid
);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy && !done) |=> busy);
   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
   // R10
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
   // R10
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_valid, mem_wr_valid, dst_set_valid, done}));
   // R7
   hpp_with_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hpp_upd_valid |-> dst_set_valid);
   // R8
   set_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_set_valid |=> done);
   // R6
   wr_then_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid && mem_wr_ready) |=> dst_set_valid);
endmodule

bind lpi_mv_unit lpi_mv_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
   .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
   .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
   .mem_wr_data(mem_wr_data), .hpp_upd_valid(hpp_upd_valid), .dst_set_valid(dst_set_valid)
);

// File: tb/test_lpi_mv_unit.sv
`timescale 1ns/1ps
module test_lpi_mv_unit;
   localparam int NUM_CPU = 3;
   localparam int ID_W    = 16;
   localparam int IDB_W   = 5;
   localparam int MAXB    = 10;
   localparam int ADDR_W  = 32;
   localparam int PA_LO   = 12;
   localparam int CPU_W   = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic                      req_valid = 1'b0;
   logic [ID_W-1:0]           req_id = '0;
   logic [CPU_W-1:0]          req_src = '0, req_dst = '0;
   logic                      busy, done;
   logic [NUM_CPU-1:0]        cpu_en;
   logic [NUM_CPU*IDB_W-1:0]  cpu_idbits;
   logic [NUM_CPU*ADDR_W-1:0] cpu_pend_base;
   logic [NUM_CPU*ID_W-1:0]   cpu_best_id;
   logic                      mem_rd_valid, mem_wr_valid;
   logic                      mem_rd_ready = 1'b0, mem_wr_ready = 1'b0;
   logic                      mem_rsp_valid = 1'b0;
   logic [7:0]                mem_rsp_data = '0;
   logic [ADDR_W-1:0]         mem_rd_addr, mem_wr_addr;
   logic [7:0]                mem_wr_data;
   logic                      hpp_upd_valid, dst_set_valid;
   logic [CPU_W-1:0]          hpp_upd_cpu, dst_set_cpu;
   logic [ID_W-1:0]           dst_set_id;

   lpi_mv_unit #(.NUM_CPU(NUM_CPU), .ID_W(ID_W), .IDB_W(IDB_W), .MAX_IDBITS(MAXB),
                 .ADDR_W(ADDR_W), .PA_LO(PA_LO)) i_lpi_mv_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_src(req_src), .req_dst(req_dst), .busy(busy), .done(done),
      .cpu_en(cpu_en), .cpu_idbits(cpu_idbits), .cpu_pend_base(cpu_pend_base),
      .cpu_best_id(cpu_best_id), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
      .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
      .mem_wr_data(mem_wr_data), .hpp_upd_valid(hpp_upd_valid), .hpp_upd_cpu(hpp_upd_cpu),
      .dst_set_valid(dst_set_valid), .dst_set_cpu(dst_set_cpu), .dst_set_id(dst_set_id)
   );

   logic [7:0] mem [logic [31:0]];
   int stall = 0, rd_wait = 0, wr_wait = 0;
   bit rsp_pend = 0;
   logic [31:0] last_rd = '0, last_wr = '0;
   logic [7:0]  last_wd = '0;
   int rd_cnt, wr_cnt, set_cnt, hpp_cnt, done_cnt;
   logic [CPU_W-1:0] set_cpu_seen, hpp_cpu_seen;
   logic [ID_W-1:0]  set_id_seen;
   int n_chk = 0, n_fail = 0;

   always @(negedge clk) begin
      if (mem_rsp_valid) mem_rsp_valid = 1'b0;
      else if (rsp_pend) begin
         mem_rsp_data  = mem.exists(last_rd) ? mem[last_rd] : 8'h00;
         mem_rsp_valid = 1'b1;
         rsp_pend      = 0;
      end
      if (mem_rd_ready) begin
         mem_rd_ready = 1'b0;
         rsp_pend     = 1;
      end else if (mem_rd_valid) begin
         if (rd_wait >= stall) begin
            mem_rd_ready = 1'b1; rd_cnt++; last_rd = mem_rd_addr; rd_wait = 0;
         end else rd_wait++;
      end
      if (mem_wr_ready) mem_wr_ready = 1'b0;
      else if (mem_wr_valid) begin
         if (wr_wait >= stall) begin
            mem_wr_ready = 1'b1; wr_cnt++; last_wr = mem_wr_addr; last_wd = mem_wr_data;
            mem[mem_wr_addr] = mem_wr_data; wr_wait = 0;
         end else wr_wait++;
      end
      if (dst_set_valid) begin set_cnt++; set_cpu_seen = dst_set_cpu; set_id_seen = dst_set_id; end
      if (hpp_upd_valid) begin hpp_cnt++; hpp_cpu_seen = hpp_upd_cpu; end
      if (done) done_cnt++;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic set_bits(input int c, input int v);
      cpu_idbits[c*IDB_W +: IDB_W] = IDB_W'(v);
   endtask

   task automatic default_cfg();
      cpu_en = '1;
      for (int c = 0; c < NUM_CPU; c++) begin
         set_bits(c, 31);
         cpu_best_id[c*ID_W +: ID_W] = 16'hFFFF;
      end
      cpu_pend_base[0*ADDR_W +: ADDR_W] = 32'h0001_0ABC;
      cpu_pend_base[1*ADDR_W +: ADDR_W] = 32'h0002_0000;
      cpu_pend_base[2*ADDR_W +: ADDR_W] = 32'h0003_0FFF;
   endtask

   task automatic run(input logic [ID_W-1:0] id, input int s, input int d, input bit extra);
      rd_cnt = 0; wr_cnt = 0; set_cnt = 0; hpp_cnt = 0; done_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1; req_id = id; req_src = CPU_W'(s); req_dst = CPU_W'(d);
      @(negedge clk);
      req_valid = 1'b0;
      if (extra) begin
         @(negedge clk);
         @(negedge clk);
         req_valid = 1'b1; req_id = id ^ 16'h0008;
         @(negedge clk);
         req_valid = 1'b0;
      end
      for (int k = 0; k < 60 && done_cnt == 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(!done && !busy, "R1 done/busy", {done, busy}, 0);
      chk(!mem_rd_valid && !mem_wr_valid, "R1 mem strobes", {mem_rd_valid, mem_wr_valid}, 0);
      chk(!dst_set_valid && !hpp_upd_valid, "R1 notify", {dst_set_valid, hpp_upd_valid}, 0);
   endtask

   task automatic t_basic();
      mem[32'h0001_0024] = 8'h5A;
      run(16'h0123, 0, 1, 0);
      chk(rd_cnt == 1 && last_rd == 32'h0001_0024, "R4 read addr", last_rd, 32'h0001_0024);
      chk(wr_cnt == 1 && last_wr == 32'h0001_0024 && last_wd == 8'h52, "R6 write byte", last_wd, 8'h52);
      chk(set_cnt == 1 && set_cpu_seen == 1 && set_id_seen == 16'h0123, "R8 dst set", set_id_seen, 16'h0123);
      chk(hpp_cnt == 0, "R7 no hpp when not best", hpp_cnt, 0);
      chk(done_cnt == 1, "R9 one done", done_cnt, 1);
   endtask

   task automatic t_best();
      cpu_best_id[2*ID_W +: ID_W] = 16'h0045;
      mem[32'h0003_0008] = 8'h20;
      run(16'h0045, 2, 0, 0);
      chk(last_rd == 32'h0003_0008, "R4 masked base", last_rd, 32'h0003_0008);
      chk(wr_cnt == 1 && last_wd == 8'h00, "R6 clear bit5", last_wd, 0);
      chk(hpp_cnt == 1 && hpp_cpu_seen == 2, "R7 hpp on src", hpp_cpu_seen, 2);
      chk(set_cnt == 1 && set_cpu_seen == 0, "R8 dst cpu0", set_cpu_seen, 0);
      cpu_best_id[2*ID_W +: ID_W] = 16'hFFFF;
   endtask

   task automatic t_clear();
      mem[32'h0003_0008] = 8'hBF;
      run(16'h0046, 2, 1, 0);
      chk(rd_cnt == 1, "R5 read done", rd_cnt, 1);
      chk(wr_cnt == 0 && set_cnt == 0 && hpp_cnt == 0, "R5 nothing after clear bit", wr_cnt + set_cnt, 0);
      chk(done_cnt == 1 && mem[32'h0003_0008] == 8'hBF, "R5 done, byte kept", mem[32'h0003_0008], 8'hBF);
   endtask

   task automatic t_disabled();
      mem[32'h0001_0024] = 8'hFF;
      cpu_en[1] = 1'b0;
      run(16'h0123, 0, 1, 0);
      chk(rd_cnt == 0 && wr_cnt == 0 && set_cnt == 0 && done_cnt == 1, "R2 dst disabled", rd_cnt + wr_cnt + set_cnt, 0);
      cpu_en[1] = 1'b1; cpu_en[0] = 1'b0;
      run(16'h0123, 0, 1, 0);
      chk(rd_cnt == 0 && set_cnt == 0 && done_cnt == 1, "R2 src disabled", rd_cnt + set_cnt, 0);
      chk(mem[32'h0001_0024] == 8'hFF, "R2 table untouched", mem[32'h0001_0024], 8'hFF);
      cpu_en[0] = 1'b1;
   endtask

   task automatic t_bound();
      set_bits(0, 2);
      mem[32'h0001_0007] = 8'h80;
      run(16'd63, 0, 1, 0);
      chk(wr_cnt == 1 && last_wr == 32'h0001_0007, "R3 id63 inside src width 2", last_wr, 32'h0001_0007);
      run(16'd64, 0, 1, 0);
      chk(rd_cnt == 0 && set_cnt == 0 && done_cnt == 1, "R3 id64 outside src width 2", rd_cnt, 0);
      set_bits(0, 31); set_bits(1, 1);
      run(16'd32, 0, 1, 0);
      chk(rd_cnt == 0 && done_cnt == 1, "R3 id32 outside dst width 1", rd_cnt, 0);
      mem[32'h0001_0003] = 8'h80;
      run(16'd31, 0, 1, 0);
      chk(wr_cnt == 1 && set_cnt == 1, "R3 id31 inside dst width 1", wr_cnt, 1);
      set_bits(1, 31);
      mem[32'h0001_07FF] = 8'h80;
      run(16'h3FFF, 0, 1, 0);
      chk(wr_cnt == 1 && last_wr == 32'h0001_07FF, "R3 global clamp inside", last_wr, 32'h0001_07FF);
      run(16'h4000, 0, 1, 0);
      chk(rd_cnt == 0 && done_cnt == 1, "R3 global clamp outside", rd_cnt, 0);
   endtask

   task automatic t_badidx();
      run(16'h0010, 3, 0, 0);
      chk(rd_cnt == 0 && set_cnt == 0 && done_cnt == 1, "R11 bad src index", rd_cnt, 0);
      run(16'h0010, 0, 3, 0);
      chk(rd_cnt == 0 && set_cnt == 0 && done_cnt == 1, "R11 bad dst index", rd_cnt, 0);
   endtask

   task automatic t_stall();
      stall = 3;
      mem[32'h0002_0002] = 8'h03;
      mem[32'h0002_0003] = 8'h03;
      run(16'h0011, 1, 2, 1);
      chk(rd_cnt == 1 && wr_cnt == 1 && last_wd == 8'h01, "R10 stalled move", last_wd, 8'h01);
      chk(done_cnt == 1 && mem[32'h0002_0003] == 8'h03, "R9 request while busy ignored", done_cnt, 1);
      chk(set_cnt == 1 && set_cpu_seen == 2 && set_id_seen == 16'h0011, "R8 stalled dst set", set_id_seen, 16'h0011);
      stall = 0;
   endtask

   initial begin
      default_cfg();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_basic();
      t_best();
      t_clear();
      t_disabled();
      t_bound();
      t_badidx();
      t_stall();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule